// File: doc/BRIEF.md
# Branch Trace Status Serializer

This block is the real-time trace output stage of a processor core's debug logic. Each clock the core gives it event strobes: a taken branch, a flag saying the branch target came from a variable addressing mode, the 32-bit target, and the stop, interrupt, halt and restart events. The block drives two 4-bit ports. The status port (`pst_o`) reports what the core is doing. The data port (`ddata_o`) carries the branch target one nibble per clock.

A taken branch is reported as the branch status code. If the target is to be shown, the report goes on with a length marker and then the target address, lowest nibble first. Only targets from variable addressing are shown. The number of address bytes is chosen when the branch is captured, and a control input can turn address display off. A branch that arrives while a report is still running waits in a small queue. A branch that finds the queue full is dropped and raises a sticky overflow flag. Stop and halt are status codes that persist over many cycles and win over any branch report.

Top module: `brtrace_ser`

## Requirements
- R1: A captured taken branch, when no report is running and the queue is empty, makes `pst_o` equal 0x5 in the cycle after the edge that sampled `br_taken_i`.
- R2: A branch with `br_variant_i` low, or with `show_addr_i` low, is reported as a single cycle of 0x5. No marker follows, and `ddata_o` stays 0x0.
- R3: For a branch whose target is shown, the cycle after 0x5 carries a marker on `pst_o` set by `addr_len_i` at capture: 0 gives 0x9 (2 bytes), 1 gives 0xA (3 bytes), and 2 or 3 gives 0xB (4 bytes).
- R4: After the marker, `ddata_o` carries 4, 6 or 8 nibbles of the target on consecutive cycles, starting with bits [3:0] and rising by 4 bits each cycle. `pst_o` reads 0x0 during these cycles.
- R5: When no nibble is being sent, `ddata_o` is 0x0. When no event is reported, `pst_o` is the idle code 0x0.
- R6: Branches captured while a report is running are queued, up to 2 of them. Their reports follow in arrival order, each starting in the cycle after the previous report's last cycle.
- R7: A branch captured while a report is running and the queue holds 2 entries is dropped, and `ovf_o` goes high. `ovf_o` stays high until reset.
- R8: A stop event makes `pst_o` read 0xE from the next cycle until the cycle after an interrupt. A running report is frozen during this time and then resumes where it left off. Branches arriving while stopped, or in the same cycle as a stop, are ignored.
- R9: A halt event makes `pst_o` read 0xF from the next cycle until the cycle after a restart, and halt wins over stop. Halt abandons the running report and empties the queue. Branches arriving while halted are ignored.
- R10: While reset is held, `pst_o` and `ddata_o` are 0x0 and `ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_taken_i | input | 1 | A branch was taken this cycle |
| br_variant_i | input | 1 | The target of that branch came from variable addressing |
| br_target_i | input | 32 | Branch target address |
| show_addr_i | input | 1 | Enables display of the target address |
| addr_len_i | input | 2 | Number of address bytes to show: 0 means 2, 1 means 3, 2 or 3 means 4 |
| stop_i | input | 1 | The core entered the stopped state |
| irq_i | input | 1 | An interrupt wakes the core from the stopped state |
| halt_i | input | 1 | The core halted |
| restart_i | input | 1 | The core restarts after a halt |
| pst_o | output | 4 | Processor status code |
| ddata_o | output | 4 | Trace data nibble |
| ovf_o | output | 1 | Sticky flag: a branch event was lost |

## Verification
The first patterns are single shown branches at each of the four length settings, with targets whose nibbles all differ. These separate a wrong marker, a wrong nibble order and a wrong nibble count. Unshown branches, both non-variant ones and ones with display turned off, show whether the marker is suppressed correctly. Bursts of two and then four branches on back-to-back cycles during a long report test queue ordering, the exact point at which an event is dropped, and whether the overflow flag stays set. Stop and halt are raised in the middle of a report and with entries in the queue. This shows the difference between freezing a report and abandoning it, confirms that halt wins over stop, and checks that branches arriving in these states are ignored.

// File: rtl/bts_pkg.sv
package bts_pkg;
   localparam int AW = 32;

   localparam logic [3:0] PST_BRANCH = 4'h5;
   localparam logic [3:0] PST_MARK0  = 4'h9;
   localparam logic [3:0] PST_STOP   = 4'hE;
   localparam logic [3:0] PST_HALT   = 4'hF;

   // len: 0 = 2 bytes, 1 = 3 bytes, 2 = 4 bytes
   typedef struct packed {
      logic [AW-1:0] addr;
      logic          show;
      logic [1:0]    len;
   } trace_ev_t;

   function automatic logic [1:0] len_code(input logic [1:0] sel);
      return (sel == 2'd3) ? 2'd2 : sel;
   endfunction
endpackage

// File: rtl/bts_evq.sv
module bts_evq
   import bts_pkg::*;
#(
   parameter int DEPTH = 2,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic            push,
   input  logic            pop,
   input  trace_ev_t       din,
   output trace_ev_t       dout,
   output logic            empty,
   output logic            full,
   output logic [CW-1:0]   count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (flush) count <= '0;
      else            count <= count + CW'(push) - CW'(pop);
   end

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));

   generate
      if (DEPTH == 1) begin : g_single
         trace_ev_t hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    hold_q <= '0;
            else if (push) hold_q <= din;
         end
         assign dout = hold_q;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         trace_ev_t      mem [DEPTH];
         logic [PW-1:0]  wp, rp;

         function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
            return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
         endfunction

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp <= '0;
               rp <= '0;
            end else if (flush) begin
               wp <= '0;
               rp <= '0;
            end else begin
               if (push) wp <= step_ptr(wp);
               if (pop)  rp <= step_ptr(rp);
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (push) begin
               mem[wp] <= din;
            end
         end

         assign dout = mem[rp];
      end
   endgenerate
endmodule

// File: rtl/bts_seq.sv
module bts_seq
   import bts_pkg::*;
#(
   parameter int SW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          hold,
   input  logic          load_valid,
   input  trace_ev_t     load_ev,
   output logic          active,
   output logic          free,
   output logic [SW-1:0] slot,
   output trace_ev_t     cur
);
   logic [SW-1:0] last;

   // slot 0: branch code, slot 1: marker, slots 2..: nibbles
   always_comb last = cur.show ? SW'(5 + 2 * int'(cur.len)) : '0;
   assign free = !active || (slot == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         slot   <= '0;
         cur    <= '0;
      end else if (clear) begin
         active <= 1'b0;
         slot   <= '0;
      end else if (!hold) begin
         if (free) begin
            if (load_valid) begin
               cur    <= load_ev;
               active <= 1'b1;
               slot   <= '0;
            end else begin
               active <= 1'b0;
            end
         end else begin
            slot <= slot + SW'(1);
         end
      end
   end
endmodule

// File: rtl/bts_out.sv
module bts_out
   import bts_pkg::*;
#(
   parameter int         SW       = 4,
   parameter logic [3:0] IDLE_PST = 4'h0
) (
   input  logic          halted,
   input  logic          stopped,
   input  logic          active,
   input  logic [SW-1:0] slot,
   input  trace_ev_t     cur,
   output logic [3:0]    pst,
   output logic [3:0]    ddata
);
   logic [AW-1:0] shifted;

   always_comb begin
      shifted = cur.addr >> {slot - SW'(2), 2'b00};
      pst     = IDLE_PST;
      ddata   = 4'h0;
      if (halted) begin
         pst = PST_HALT;
      end else if (stopped) begin
         pst = PST_STOP;
      end else if (active) begin
         if (slot == '0)             pst = PST_BRANCH;
         else if (slot == SW'(1))    pst = PST_MARK0 + {2'b00, cur.len};
         else                        ddata = shifted[3:0];
      end
   end
endmodule

// File: rtl/brtrace_ser.sv
module brtrace_ser
   import bts_pkg::*;
#(
   parameter int         QUEUE_DEPTH = 2,
   parameter logic [3:0] IDLE_PST    = 4'h0,
   localparam int        SW          = 4,
   localparam int        CW          = $clog2(QUEUE_DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          br_taken_i,
   input  logic          br_variant_i,
   input  logic [31:0]   br_target_i,
   input  logic          show_addr_i,
   input  logic [1:0]    addr_len_i,
   input  logic          stop_i,
   input  logic          irq_i,
   input  logic          halt_i,
   input  logic          restart_i,
   output logic [3:0]    pst_o,
   output logic [3:0]    ddata_o,
   output logic          ovf_o
);
   generate
      if (QUEUE_DEPTH < 1) begin : g_bad_depth
         $error("brtrace_ser: QUEUE_DEPTH must be at least 1");
      end
      if (AW != 32) begin : g_bad_width
         $error("brtrace_ser: event address width must be 32");
      end
      if (IDLE_PST >= PST_BRANCH) begin : g_bad_idle
         $error("brtrace_ser: idle code must lie below the branch code");
      end
   endgenerate

   logic halted_q, stopped_q, halted_n, stopped_n, run;
   logic accept, push, pop, drop, load_valid;
   logic q_empty, q_full, seq_active, seq_free;
   logic [CW-1:0] q_count;
   logic [SW-1:0] seq_slot;
   trace_ev_t     inc_ev, q_head, load_ev, cur_ev;

   assign halted_n  = halt_i | (halted_q & ~restart_i);
   assign stopped_n = ~halt_i & (stop_i | (stopped_q & ~irq_i));
   assign run       = ~halted_n & ~stopped_n;
   assign accept    = br_taken_i & ~halted_q & ~stopped_q & ~halt_i & ~stop_i;

   always_comb begin
      inc_ev.addr = br_target_i;
      inc_ev.show = br_variant_i & show_addr_i;
      inc_ev.len  = len_code(addr_len_i);
   end

   assign pop        = run & seq_free & ~q_empty;
   assign drop       = accept & ~seq_free & q_full;
   assign push       = accept & (~q_empty | ~seq_free) & ~drop;
   assign load_valid = run & seq_free & (~q_empty | accept);
   assign load_ev    = q_empty ? inc_ev : q_head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_q  <= 1'b0;
         stopped_q <= 1'b0;
         ovf_o     <= 1'b0;
      end else begin
         halted_q  <= halted_n;
         stopped_q <= stopped_n;
         ovf_o     <= ovf_o | drop;
      end
   end

   bts_evq #(.DEPTH(QUEUE_DEPTH)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (halted_n),
      .push  (push),
      .pop   (pop),
      .din   (inc_ev),
      .dout  (q_head),
      .empty (q_empty),
      .full  (q_full),
      .count (q_count)
   );

   bts_seq #(.SW(SW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (halted_n),
      .hold       (stopped_n),
      .load_valid (load_valid),
      .load_ev    (load_ev),
      .active     (seq_active),
      .free       (seq_free),
      .slot       (seq_slot),
      .cur        (cur_ev)
   );

   bts_out #(.SW(SW), .IDLE_PST(IDLE_PST)) u_out (
      .halted  (halted_q),
      .stopped (stopped_q),
      .active  (seq_active),
      .slot    (seq_slot),
      .cur     (cur_ev),
      .pst     (pst_o),
      .ddata   (ddata_o)
   );
endmodule

// File: rtl/brtrace_ser_chk.sv
module brtrace_ser_chk
   import bts_pkg::*;
#(
   parameter int         QUEUE_DEPTH = 2,
   parameter logic [3:0] IDLE_PST    = 4'h0,
   localparam int        CW          = $clog2(QUEUE_DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          stop_i,
   input logic          halt_i,
   input logic [3:0]    pst_o,
   input logic [3:0]    ddata_o,
   input logic          ovf_o,
   input logic [CW-1:0] q_count
);
   assert_halt_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halt_i |=> pst_o == PST_HALT);

   assert_stop_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !halt_i && pst_o != PST_HALT) |=> pst_o == PST_STOP);

   assert_data_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ddata_o != 4'h0 |-> pst_o == IDLE_PST);

   assert_marker_after_branch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pst_o == 4'h9 || pst_o == 4'hA || pst_o == 4'hB)
      |-> ($past(pst_o) == PST_BRANCH || $past(pst_o) == PST_STOP));

   assert_no_overflow_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);

   assert_queue_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(QUEUE_DEPTH));
endmodule

bind brtrace_ser brtrace_ser_chk #(.QUEUE_DEPTH(QUEUE_DEPTH), .IDLE_PST(IDLE_PST)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .stop_i  (stop_i),
   .halt_i  (halt_i),
   .pst_o   (pst_o),
   .ddata_o (ddata_o),
   .ovf_o   (ovf_o),
   .q_count (q_count)
);

// File: tb/brtrace_ser_test.sv
module brtrace_ser_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        br_taken_i = 1'b0, br_variant_i = 1'b0, show_addr_i = 1'b1;
   logic [31:0] br_target_i = '0;
   logic [1:0]  addr_len_i = '0;
   logic        stop_i = 1'b0, irq_i = 1'b0, halt_i = 1'b0, restart_i = 1'b0;
   logic [3:0]  pst_o, ddata_o;
   logic        ovf_o;

   int checks = 0, errors = 0;
   bit done = 0;
   string tag = "R10";

   always #5 clk = ~clk;

   brtrace_ser uut (
      .clk(clk), .rst_n(rst_n), .br_taken_i(br_taken_i), .br_variant_i(br_variant_i),
      .br_target_i(br_target_i), .show_addr_i(show_addr_i), .addr_len_i(addr_len_i),
      .stop_i(stop_i), .irq_i(irq_i), .halt_i(halt_i), .restart_i(restart_i),
      .pst_o(pst_o), .ddata_o(ddata_o), .ovf_o(ovf_o)
   );

   // behavioural reference model
   typedef struct { logic [31:0] a; bit has; int nb; } ev_t;
   ev_t q[$];
   ev_t m_cur;
   bit  m_act = 0, m_halt = 0, m_stop = 0, m_ovf = 0;
   int  m_slot = 0;

   function automatic int last_of(ev_t e);
      return e.has ? 5 + 2 * e.nb : 0;
   endfunction

   always @(posedge clk) begin : model
      bit  acc, fr;
      ev_t e;
      if (!rst_n) begin
         m_act = 0; m_halt = 0; m_stop = 0; m_ovf = 0; m_slot = 0; q.delete();
      end else begin
         acc  = br_taken_i && !m_halt && !m_stop && !halt_i && !stop_i;
         e.a  = br_target_i;
         e.has = br_variant_i && show_addr_i;
         e.nb = (addr_len_i == 2'd3) ? 2 : int'(addr_len_i);
         if (halt_i) begin
            m_halt = 1; m_stop = 0;
         end else begin
            if (restart_i) m_halt = 0;
            if (stop_i) m_stop = 1;
            else if (irq_i) m_stop = 0;
         end
         if (m_halt) begin
            m_act = 0; q.delete();
         end else if (!m_stop) begin
            fr = !m_act || m_slot == last_of(m_cur);
            if (fr) begin
               if (q.size() > 0) begin
                  m_cur = q.pop_front(); m_act = 1; m_slot = 0;
                  if (acc) q.push_back(e);
               end else if (acc) begin
                  m_cur = e; m_act = 1; m_slot = 0;
               end else m_act = 0;
            end else begin
               m_slot++;
               if (acc) begin
                  if (q.size() < 2) q.push_back(e);
                  else m_ovf = 1;
               end
            end
         end
      end
   end

   function automatic logic [3:0] exp_pst();
      if (m_halt) return 4'hF;
      if (m_stop) return 4'hE;
      if (!m_act) return 4'h0;
      if (m_slot == 0) return 4'h5;
      if (m_slot == 1) return 4'(9 + m_cur.nb);
      return 4'h0;
   endfunction

   function automatic logic [3:0] exp_dd();
      if (m_halt || m_stop || !m_act || m_slot < 2) return 4'h0;
      return m_cur.a[4*(m_slot-2) +: 4];
   endfunction

   task automatic check_now();
      logic [3:0] ep, ed;
      ep = exp_pst();
      ed = exp_dd();
      checks++;
      if (pst_o !== ep || ddata_o !== ed || ovf_o !== m_ovf) begin
         errors++;
         $display("FAIL %s t=%0t: actual pst=%h dd=%h ovf=%b expected pst=%h dd=%h ovf=%b",
                  tag, $time, pst_o, ddata_o, ovf_o, ep, ed, m_ovf);
      end
   endtask

   task automatic step(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check_now();
         br_taken_i = 0; stop_i = 0; irq_i = 0; halt_i = 0; restart_i = 0;
      end
   endtask

   task automatic branch(logic [31:0] a, bit variant, logic [1:0] len);
      br_taken_i = 1; br_variant_i = variant; br_target_i = a; addr_len_i = len;
   endtask

   initial begin
      tag = "R10";                         // reset state
      step(3);
      rst_n = 1;
      tag = "R1";  branch(32'h1234_ABCD, 1, 2'd0); step(8);      // R1 R3 R4: 2 bytes
      tag = "R3";  branch(32'h89AB_CDEF, 1, 2'd1); step(10);     // 3 bytes, marker 0xA
      tag = "R4";  branch(32'hFEDC_BA98, 1, 2'd2); step(12);     // 4 bytes, nibble order
      tag = "R4";  branch(32'h0F1E_2D3C, 1, 2'd3); step(12);     // code 3 also 4 bytes
      tag = "R2";  branch(32'hDEAD_BEEF, 0, 2'd2); step(3);      // non-variant: 0x5 only
      show_addr_i = 0;
      tag = "R2";  branch(32'hCAFE_F00D, 1, 2'd2); step(3);      // display off
      show_addr_i = 1;
      tag = "R5";  step(2);                                      // idle outputs
      tag = "R6";  branch(32'h7654_3210, 1, 2'd2); step();       // queue of two
      branch(32'h1111_2222, 0, 2'd0); step();
      branch(32'hA5A5_5A5A, 1, 2'd0); step(25);
      tag = "R7";  branch(32'h0102_0304, 1, 2'd2); step();       // four in a row: one dropped
      branch(32'h0506_0708, 1, 2'd0); step();
      branch(32'h090A_0B0C, 1, 2'd1); step();
      branch(32'h0D0E_0F00, 1, 2'd0); step(32);
      tag = "R8";  branch(32'h3C3C_A5A5, 1, 2'd2); step(3);      // stop mid-report
      stop_i = 1; step(2);
      branch(32'h9999_9999, 1, 2'd0); step(3);                   // ignored while stopped
      irq_i = 1; step(14);
      tag = "R9";  branch(32'h4444_5555, 1, 2'd2); step();       // halt mid-report
      branch(32'h6666_7777, 1, 2'd0); step();
      branch(32'h8888_9999, 1, 2'd1); step();
      halt_i = 1; step();
      stop_i = 1; step();
      branch(32'hBBBB_CCCC, 1, 2'd0); step(2);
      restart_i = 1; step(3);
      branch(32'h5A5A_1234, 1, 2'd0); step(8);
      halt_i = 1; stop_i = 1; step(2);                           // halt wins over stop
      restart_i = 1; step(4);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog: actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule